// File: doc/BRIEF.md
# Planar Display Memory Read Unit

This block serves byte reads issued by a host processor into a display memory that is organised as four parallel 8-bit planes. The host presents a 20-bit address. The block matches it against one of four selectable address windows and converts it into an offset within that window. The offset is then resolved in one of three ways. In a chained pixel mode each byte of the window lands in a different plane. In a flat mode the planes are addressed as one linear byte array. In the planar mode one offset touches all four planes at once.

A planar read has a side effect: it captures the four plane bytes into four latches, which are exported so that a companion write unit can merge them into later writes. The returned byte is picked by one of two read modes. The first returns a single latched plane byte. The second returns, for each of the eight pixels in the byte, whether the 4-bit pixel colour matches a reference colour, with only the planes that a care mask selects taking part in the comparison.

The plane storage sits inside the block, and the block provides a plane-masked write port for filling it. A read is accepted in the cycle it is requested, and its result comes back one cycle later.

Top module: `mrd_planar_read`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset is released, `rd_valid` is 0, `rd_data` is 0x00 and all four latches read 0x00.
- R2: `rd_valid` is 1 in the cycle after each cycle in which `rd_req` is 1, and 0 otherwise. `rd_data` carries the result of that read while `rd_valid` is 1.
- R3: The window is chosen by `map_sel`. With `map_sel`=0 the window is 0xA0000..0xBFFFF with base 0xA0000. With 1 it is 0xA0000..0xAFFFF with base 0xA0000. With 2 it is 0xB0000..0xB7FFF with base 0xB0000. With 3 it is 0xB8000..0xBFFFF with base 0xB8000. The offset is the address minus the base.
- R4: A read whose address lies outside the selected window returns 0xFF and leaves the latches unchanged.
- R5: When `chain4_en`=1 (and the address is in the window), the byte comes from plane offset[1:0], at index offset with bits [1:0] cleared, modulo the plane depth. The latches are unchanged. This applies for every `map_sel`.
- R6: When `chain4_en`=0 and `map_sel`!=1, the read is flat. The plane is (offset / depth) mod 4 and the index is offset mod depth. The latches are unchanged.
- R7: When `chain4_en`=0, `map_sel`=1 and `rd_mode`=0, all four plane bytes at index (offset mod depth) are loaded into the latches. Plane p sits in `latch_bytes[8p+7:8p]`. The returned byte is the plane that `map_pick` selects.
- R8: When `chain4_en`=0, `map_sel`=1 and `rd_mode`=1, the latches are loaded as in R7. Bit b of the result is 1 exactly when (pixel AND `cmp_care`) equals (`cmp_color` AND `cmp_care`). The pixel is {plane3[b], plane2[b], plane1[b], plane0[b]}.
- R9: When `chain4_en`=0, `map_sel`=1 and `rd_mode` is 2 or 3, the read returns 0x00 and the latches are unchanged.
- R10: With `wr_en`=1, each plane p whose bit is set in `wr_planes` stores `wr_bytes[8p+7:8p]` at `wr_idx`. Planes whose bit is clear keep their contents. Reads issued after that edge see the new data.
- R11: The latches change only on a read that falls under R7 or R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read request, one per cycle |
| rd_addr | input | 20 | Host byte address |
| map_sel | input | 2 | Window mapping select |
| chain4_en | input | 1 | Chained byte-per-pixel addressing |
| rd_mode | input | 2 | Read mode (0 plane byte, 1 colour compare) |
| map_pick | input | 2 | Plane returned in read mode 0 |
| cmp_color | input | 4 | Reference colour for read mode 1 |
| cmp_care | input | 4 | Planes taking part in the compare |
| wr_en | input | 1 | Plane write enable |
| wr_planes | input | 4 | Per-plane write mask |
| wr_idx | input | IDX_W | Plane byte index for writes |
| wr_bytes | input | 32 | Write data, plane p in bits [8p+7:8p] |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read result byte |
| latch_bytes | output | 32 | Four plane latches, plane p in bits [8p+7:8p] |

## Verification
A wrong window decode shows up in the cycle after the request, either as a stray 0xFF or as a real byte where 0xFF was due. A wrong plane or index choice in the chained or flat paths likewise corrupts that single returned byte at once. A latch that was not loaded, or that was disturbed by a flat, chained, outside or mode-2/3 read, is visible on `latch_bytes` in the very next cycle. It also poisons every later mode-0 and mode-1 result, so the bench compares the latches after every read and idle cycle. An error in the compare mask shows as individual wrong bits in mode-1 results, which only varied colour and care patterns expose.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

    localparam int PLANES   = 4;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 20;
    localparam int PIX_W    = PLANES;

    localparam logic [ADDR_W-1:0] WIN_LO_A   = 20'hA0000;
    localparam logic [ADDR_W-1:0] WIN_HI_A   = 20'hAFFFF;
    localparam logic [ADDR_W-1:0] WIN_LO_B0  = 20'hB0000;
    localparam logic [ADDR_W-1:0] WIN_HI_B0  = 20'hB7FFF;
    localparam logic [ADDR_W-1:0] WIN_LO_B8  = 20'hB8000;
    localparam logic [ADDR_W-1:0] WIN_HI_ALL = 20'hBFFFF;

    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_CHAIN  = 2'd1,
        ACC_FLAT   = 2'd2,
        ACC_PLANAR = 2'd3
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e         kind;
        logic [ADDR_W-1:0] ofs;
    } win_hit_t;

    function automatic win_hit_t decode_window(input logic [ADDR_W-1:0] addr,
                                               input logic [1:0]        map,
                                               input logic              chain);
        win_hit_t          r;
        logic              hit;
        logic [ADDR_W-1:0] base;
        case (map)
            2'd0: begin hit = (addr >= WIN_LO_A)  && (addr <= WIN_HI_ALL); base = WIN_LO_A;  end
            2'd1: begin hit = (addr >= WIN_LO_A)  && (addr <= WIN_HI_A);   base = WIN_LO_A;  end
            2'd2: begin hit = (addr >= WIN_LO_B0) && (addr <= WIN_HI_B0);  base = WIN_LO_B0; end
            default: begin hit = (addr >= WIN_LO_B8) && (addr <= WIN_HI_ALL); base = WIN_LO_B8; end
        endcase
        r.ofs = addr - base;
        if (!hit)            r.kind = ACC_NONE;
        else if (chain)      r.kind = ACC_CHAIN;
        else if (map != 2'd1) r.kind = ACC_FLAT;
        else                 r.kind = ACC_PLANAR;
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] colour_match(input logic [PLANES*BYTE_W-1:0] pl,
                                                       input logic [PIX_W-1:0]         colour,
                                                       input logic [PIX_W-1:0]         care);
        logic [BYTE_W-1:0] r;
        logic [PIX_W-1:0]  pix;
        for (int b = 0; b < BYTE_W; b++) begin
            for (int p = 0; p < PLANES; p++) pix[p] = pl[p*BYTE_W + b];
            r[b] = ((pix ^ colour) & care) == '0;
        end
        return r;
    endfunction

endpackage

// File: rtl/mrd_addr_map.sv
module mrd_addr_map
    import mrd_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        map,
    input  logic              chain,
    output acc_kind_e         kind,
    output logic [1:0]        plane_sel,
    output logic [IDX_W-1:0]  idx
);
    win_hit_t hit;
    logic     unused_ofs_bits;

    assign hit             = decode_window(addr, map, chain);
    assign kind            = hit.kind;
    assign unused_ofs_bits = ^hit.ofs[ADDR_W-1:IDX_W+2];

    always_comb begin
        case (hit.kind)
            ACC_CHAIN: begin
                plane_sel = hit.ofs[1:0];
                idx       = {hit.ofs[IDX_W-1:2], 2'b00};
            end
            ACC_FLAT: begin
                plane_sel = hit.ofs[IDX_W+1:IDX_W];
                idx       = hit.ofs[IDX_W-1:0];
            end
            default: begin
                plane_sel = 2'd0;
                idx       = hit.ofs[IDX_W-1:0];
            end
        endcase
    end
endmodule

// File: rtl/mrd_plane_bank.sv
module mrd_plane_bank
    import mrd_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       wr_en,
    input  logic [PLANES-1:0]          wr_planes,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [PLANES*BYTE_W-1:0]   wr_bytes,
    input  logic [IDX_W-1:0]           rd_idx,
    output logic [PLANES*BYTE_W-1:0]   rd_bytes
);
    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        logic [BYTE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_planes[p]) mem[wr_idx] <= wr_bytes[p*BYTE_W +: BYTE_W];
        end

        assign rd_bytes[p*BYTE_W +: BYTE_W] = mem[rd_idx];
    end
endmodule

// File: rtl/mrd_result_sel.sv
module mrd_result_sel
    import mrd_pkg::*;
(
    input  acc_kind_e                kind,
    input  logic [1:0]               plane_sel,
    input  logic [PLANES*BYTE_W-1:0] bytes,
    input  logic [1:0]               mode,
    input  logic [1:0]               pick,
    input  logic [PIX_W-1:0]         colour,
    input  logic [PIX_W-1:0]         care,
    output logic [BYTE_W-1:0]        result,
    output logic                     load_latch
);
    always_comb begin
        result     = '0;
        load_latch = 1'b0;
        case (kind)
            ACC_NONE: result = '1;
            ACC_CHAIN, ACC_FLAT: result = bytes[plane_sel*BYTE_W +: BYTE_W];
            default: begin
                case (mode)
                    2'd0: begin
                        result     = bytes[pick*BYTE_W +: BYTE_W];
                        load_latch = 1'b1;
                    end
                    2'd1: begin
                        result     = colour_match(bytes, colour, care);
                        load_latch = 1'b1;
                    end
                    default: result = '0;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/mrd_planar_read.sv
module mrd_planar_read
    import mrd_pkg::*;
#(
    parameter int PLANE_DEPTH = 1024,
    localparam int IDX_W = $clog2(PLANE_DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      rd_req,
    input  logic [ADDR_W-1:0]         rd_addr,
    input  logic [1:0]                map_sel,
    input  logic                      chain4_en,
    input  logic [1:0]                rd_mode,
    input  logic [1:0]                map_pick,
    input  logic [PIX_W-1:0]          cmp_color,
    input  logic [PIX_W-1:0]          cmp_care,
    input  logic                      wr_en,
    input  logic [PLANES-1:0]         wr_planes,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [PLANES*BYTE_W-1:0]  wr_bytes,
    output logic                      rd_valid,
    output logic [BYTE_W-1:0]         rd_data,
    output logic [PLANES*BYTE_W-1:0]  latch_bytes
);
    acc_kind_e                kind;
    logic [1:0]               plane_sel;
    logic [IDX_W-1:0]         rd_idx;
    logic [PLANES*BYTE_W-1:0] bank_bytes;
    logic [BYTE_W-1:0]        nxt_data;
    logic                     nxt_load;

    mrd_addr_map #(.IDX_W(IDX_W)) u_map (
        .addr      (rd_addr),
        .map       (map_sel),
        .chain     (chain4_en),
        .kind      (kind),
        .plane_sel (plane_sel),
        .idx       (rd_idx)
    );

    mrd_plane_bank #(.DEPTH(PLANE_DEPTH)) u_bank (
        .clk       (clk),
        .wr_en     (wr_en),
        .wr_planes (wr_planes),
        .wr_idx    (wr_idx),
        .wr_bytes  (wr_bytes),
        .rd_idx    (rd_idx),
        .rd_bytes  (bank_bytes)
    );

    mrd_result_sel u_sel (
        .kind       (kind),
        .plane_sel  (plane_sel),
        .bytes      (bank_bytes),
        .mode       (rd_mode),
        .pick       (map_pick),
        .colour     (cmp_color),
        .care       (cmp_care),
        .result     (nxt_data),
        .load_latch (nxt_load)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid    <= 1'b0;
            rd_data     <= '0;
            latch_bytes <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) rd_data <= nxt_data;
            if (rd_req && nxt_load) latch_bytes <= bank_bytes;
        end
    end
endmodule

// File: rtl/mrd_read_checker.sv
module mrd_read_checker (
    input logic        clk,
    input logic        rst,
    input logic        rd_req,
    input logic [19:0] rd_addr,
    input logic [1:0]  map_sel,
    input logic        chain4_en,
    input logic [1:0]  rd_mode,
    input logic [1:0]  map_pick,
    input logic        rd_valid,
    input logic [7:0]  rd_data,
    input logic [31:0] latch_bytes
);
    logic       in_win;
    logic [1:0] pick_q;

    always_comb begin
        case (map_sel)
            2'd0:    in_win = rd_addr >= 20'hA0000 && rd_addr <= 20'hBFFFF;
            2'd1:    in_win = rd_addr >= 20'hA0000 && rd_addr <= 20'hAFFFF;
            2'd2:    in_win = rd_addr >= 20'hB0000 && rd_addr <= 20'hB7FFF;
            default: in_win = rd_addr >= 20'hB8000 && rd_addr <= 20'hBFFFF;
        endcase
    end

    always_ff @(posedge clk) pick_q <= map_pick;

    function automatic logic [7:0] byte_of(input logic [31:0] v, input logic [1:0] p);
        return v[p*8 +: 8];
    endfunction

    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_valid);
    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rd_valid);
    // R4
    outside_ff_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req && !in_win |=> rd_data == 8'hFF && $stable(latch_bytes));
    // R11
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> $stable(latch_bytes));
    // R6
    flat_latch_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req && map_sel != 2'd1 |=> $stable(latch_bytes));
    // R5
    chain_latch_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req && chain4_en |=> $stable(latch_bytes));
    // R9
    mode_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req && in_win && !chain4_en && map_sel == 2'd1 && rd_mode[1]
        |=> rd_data == 8'h00 && $stable(latch_bytes));
    // R7
    pick_match_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req && in_win && !chain4_en && map_sel == 2'd1 && rd_mode == 2'd0
        |=> rd_data == byte_of(latch_bytes, pick_q));
endmodule

bind mrd_planar_read mrd_read_checker u_mrd_read_checker (
    .clk         (clk),
    .rst         (rst),
    .rd_req      (rd_req),
    .rd_addr     (rd_addr),
    .map_sel     (map_sel),
    .chain4_en   (chain4_en),
    .rd_mode     (rd_mode),
    .map_pick    (map_pick),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .latch_bytes (latch_bytes)
);

// File: tb/test_mrd_planar_read.sv
`timescale 1ns/1ps
module test_mrd_planar_read;
    localparam int DEPTH = 256;
    localparam int IW    = $clog2(DEPTH);

    logic        clk = 1'b0;
    logic        rst;
    logic        rd_req;
    logic [19:0] rd_addr;
    logic [1:0]  map_sel;
    logic        chain4_en;
    logic [1:0]  rd_mode;
    logic [1:0]  map_pick;
    logic [3:0]  cmp_color;
    logic [3:0]  cmp_care;
    logic        wr_en;
    logic [3:0]  wr_planes;
    logic [IW-1:0] wr_idx;
    logic [31:0] wr_bytes;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [31:0] latch_bytes;

    int checks = 0;
    int errors = 0;
    logic [7:0]  ref_mem [4][DEPTH];
    logic [31:0] exp_latch;

    always #2.5 clk = ~clk;

    mrd_planar_read #(.PLANE_DEPTH(DEPTH)) i_mrd_planar_read (
        .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr), .map_sel(map_sel),
        .chain4_en(chain4_en), .rd_mode(rd_mode), .map_pick(map_pick),
        .cmp_color(cmp_color), .cmp_care(cmp_care), .wr_en(wr_en),
        .wr_planes(wr_planes), .wr_idx(wr_idx), .wr_bytes(wr_bytes),
        .rd_valid(rd_valid), .rd_data(rd_data), .latch_bytes(latch_bytes)
    );

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired: actual hung, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pattern(input int p, input int i);
        return 8'((i * 7) + (p * 61) + (i >> 3) + ((i & 1) * 128));
    endfunction

    task automatic plane_write(input logic [3:0] mask, input int idx, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_planes = mask; wr_idx = IW'(idx); wr_bytes = data;
        for (int p = 0; p < 4; p++) if (mask[p]) ref_mem[p][idx] = data[p*8 +: 8];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Reference: independent reading of R3..R9
    task automatic expect_read(input logic [19:0] a, input logic [1:0] m, input logic ch,
                               input logic [1:0] md, input logic [1:0] pk,
                               input logic [3:0] col, input logic [3:0] care,
                               output logic [7:0] ed, output logic ld, output string tag);
        logic        inw;
        logic [19:0] base, ofs;
        int          idx, pl;
        logic [31:0] four;
        logic [3:0]  pix;
        case (m)
            2'd0: begin inw = a >= 20'hA0000 && a <= 20'hBFFFF; base = 20'hA0000; end
            2'd1: begin inw = a >= 20'hA0000 && a <= 20'hAFFFF; base = 20'hA0000; end
            2'd2: begin inw = a >= 20'hB0000 && a <= 20'hB7FFF; base = 20'hB0000; end
            default: begin inw = a >= 20'hB8000 && a <= 20'hBFFFF; base = 20'hB8000; end
        endcase
        ofs = a - base;
        ld  = 1'b0;
        if (!inw) begin
            ed = 8'hFF; tag = "R4";
        end else if (ch) begin
            pl = int'(ofs % 4); idx = int'((ofs - (ofs % 4)) % DEPTH);
            ed = ref_mem[pl][idx]; tag = "R5";
        end else if (m != 2'd1) begin
            pl = int'((ofs / DEPTH) % 4); idx = int'(ofs % DEPTH);
            ed = ref_mem[pl][idx]; tag = "R6";
        end else begin
            idx = int'(ofs % DEPTH);
            for (int p = 0; p < 4; p++) four[p*8 +: 8] = ref_mem[p][idx];
            if (md == 2'd0) begin
                ed = four[pk*8 +: 8]; ld = 1'b1; tag = "R7";
            end else if (md == 2'd1) begin
                for (int b = 0; b < 8; b++) begin
                    pix = {four[24+b], four[16+b], four[8+b], four[b]};
                    ed[b] = (pix & care) == (col & care);
                end
                ld = 1'b1; tag = "R8";
            end else begin
                ed = 8'h00; tag = "R9";
            end
            if (ld) exp_latch = four;
        end
    endtask

    task automatic do_read(input logic [19:0] a, input logic [1:0] m, input logic ch,
                           input logic [1:0] md, input logic [1:0] pk,
                           input logic [3:0] col, input logic [3:0] care);
        logic [7:0] ed;
        logic       ld;
        string      tag;
        @(negedge clk);
        expect_read(a, m, ch, md, pk, col, care, ed, ld, tag);
        rd_req = 1'b1; rd_addr = a; map_sel = m; chain4_en = ch;
        rd_mode = md; map_pick = pk; cmp_color = col; cmp_care = care;
        @(negedge clk);
        rd_req = 1'b0;
        chk("R2 valid", 32'(rd_valid), 32'd1);
        chk({tag, " data"}, 32'(rd_data), 32'(ed));
        chk({tag, " latch (R11)"}, latch_bytes, exp_latch);
    endtask

    initial begin
        void'($urandom(32'd7331));
        rst = 1'b1; rd_req = 1'b0; rd_addr = '0; map_sel = '0; chain4_en = 1'b0;
        rd_mode = '0; map_pick = '0; cmp_color = '0; cmp_care = '0;
        wr_en = 1'b0; wr_planes = '0; wr_idx = '0; wr_bytes = '0;
        exp_latch = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 valid", 32'(rd_valid), 32'd0);
        chk("R1 data", 32'(rd_data), 32'd0);
        chk("R1 latch", latch_bytes, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid after release", 32'(rd_valid), 32'd0);

        // R10 preload all four planes in one write per index
        for (int i = 0; i < DEPTH; i++)
            plane_write(4'hF, i, {pattern(3, i), pattern(2, i), pattern(1, i), pattern(0, i)});

        // R7 mode 0, each plane picked
        for (int p = 0; p < 4; p++) do_read(20'hA0005, 2'd1, 1'b0, 2'd0, 2'(p), 4'h0, 4'h0);
        // R8 care mask 0 -> all ones, full mask, partial mask
        do_read(20'hA0011, 2'd1, 1'b0, 2'd1, 2'd0, 4'h5, 4'h0);
        chk("R8 no-care all ones", 32'(rd_data), 32'hFF);
        do_read(20'hA0012, 2'd1, 1'b0, 2'd1, 2'd0, 4'hA, 4'hF);
        do_read(20'hA0013, 2'd1, 1'b0, 2'd1, 2'd0, 4'h3, 4'h6);
        // R9 modes 2 and 3
        do_read(20'hA0020, 2'd1, 1'b0, 2'd2, 2'd0, 4'h0, 4'h0);
        do_read(20'hA0021, 2'd1, 1'b0, 2'd3, 2'd1, 4'h0, 4'h0);
        // R3/R4 window edges
        do_read(20'hB0000, 2'd1, 1'b0, 2'd0, 2'd0, 4'h0, 4'h0);
        do_read(20'hAFFFF, 2'd1, 1'b0, 2'd0, 2'd2, 4'h0, 4'h0);
        do_read(20'h9FFFF, 2'd0, 1'b0, 2'd0, 2'd0, 4'h0, 4'h0);
        do_read(20'hC0000, 2'd0, 1'b0, 2'd0, 2'd0, 4'h0, 4'h0);
        do_read(20'hBFFFF, 2'd0, 1'b0, 2'd0, 2'd0, 4'h0, 4'h0);
        do_read(20'hB7FFF, 2'd2, 1'b0, 2'd0, 2'd0, 4'h0, 4'h0);
        do_read(20'hB8000, 2'd2, 1'b0, 2'd0, 2'd0, 4'h0, 4'h0);
        do_read(20'hB8000, 2'd3, 1'b0, 2'd0, 2'd0, 4'h0, 4'h0);
        do_read(20'hB7FFF, 2'd3, 1'b0, 2'd0, 2'd0, 4'h0, 4'h0);
        // R5 chained: offset 7 -> plane 3, index 4
        do_read(20'hA0007, 2'd1, 1'b1, 2'd0, 2'd0, 4'h0, 4'h0);
        chk("R5 plane3 idx4", 32'(rd_data), 32'(pattern(3, 4)));
        do_read(20'hB8102, 2'd3, 1'b1, 2'd1, 2'd0, 4'h0, 4'h0);
        // R6 flat: offset 0x10123 -> plane 1, index 0x23
        do_read(20'hB0123, 2'd0, 1'b0, 2'd0, 2'd0, 4'h0, 4'h0);
        chk("R6 plane1 idx23", 32'(rd_data), 32'(pattern(1, 8'h23)));
        // R10 masked write, then planar read
        plane_write(4'b0101, 9, 32'hDEADBEEF);
        do_read(20'hA0009, 2'd1, 1'b0, 2'd0, 2'd0, 4'h0, 4'h0);
        chk("R10 masked latch", latch_bytes,
            {pattern(3, 9), 8'hAD, pattern(1, 9), 8'hEF});
        // R2/R11 idle cycle
        @(negedge clk);
        chk("R2 idle valid", 32'(rd_valid), 32'd0);
        chk("R11 idle latch", latch_bytes, exp_latch);

        // Random mix
        for (int n = 0; n < 600; n++) begin
            logic [19:0] a;
            if (($urandom % 4) != 0) a = 20'hA0000 + 20'($urandom % 32'h20000);
            else                     a = 20'($urandom);
            do_read(a, 2'($urandom), (($urandom % 5) == 0), 2'($urandom),
                    2'($urandom), 4'($urandom), 4'($urandom));
            if (($urandom % 8) == 0) begin
                @(negedge clk);
                chk("R2 gap valid", 32'(rd_valid), 32'd0);
                chk("R11 gap latch", latch_bytes, exp_latch);
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule